// File: doc/BRIEF.md
# Horizontal Drive Timing Generator for Delta-Pixel Panels

This block produces the horizontal drive waveforms for an active-matrix panel with pixels laid out in a delta pattern and an on-glass bidirectional horizontal shift register. It runs on a master clock four times the shift-clock rate. Each line begins with a one-cycle line strobe. The block then issues a start pulse, a complementary two-phase shift clock for a mode-dependent number of bits, and three staggered one-tick sample strobes for the external video delay stage.

On alternate lines, every horizontal edge moves later by one and a half shift-register bits, which follows the delta offset of the pixels. A parity register toggles on each line and is forced to even by a frame strobe. The parity drives a polarity flag, which the video path uses for the line-by-line inversion of both the picture signal and the side-black signal. The aspect (wide or narrow) and scan direction (right or left) inputs are captured only at a line start. They are echoed on the panel mode outputs.

Top module: `hdrv_timing_top`

## Requirements
- R1: After reset: hst=0, hck1=0, hck2=1, all three sample strobes 0, pol=0, wid_o=1, rgt_o=1.
- R2: Tick k counts master-clock edges after the edge that samples line_start (k=0 is the first cycle after that edge). hst is high for exactly 4 ticks. On an even line (pol=0) it starts at k=0. On an odd line (pol=1) it starts at k=6, an offset of 1.5 bits.
- R3: hck2 is the inverse of hck1 in every cycle, including idle cycles.
- R4: The first hck1 rise comes one tick after hst rises, which leaves 3 ticks of hold after that edge. hck1 then has a period of 4 ticks: high for 2 ticks, low for 2. The line has 357 hck1 periods when wide was latched high and 268 when it was latched low. After the line, hck1 stays 0.
- R5: With right scan latched (rgt_o=1), the strobes pulse within each shift-clock period at these phases: sh_ck1 at phase 0 (the tick where hck1 rises), sh_ck2 at phase 1 and sh_ck3 at phase 2. Each pulse lasts one tick. At most one strobe is high in any cycle, and all are low outside the line.
- R6: With left scan latched (rgt_o=0), the phases of sh_ck2 and sh_ck3 are exchanged: sh_ck3 pulses at phase 1 and sh_ck2 at phase 2.
- R7: pol inverts on each line_start. When frame_start is high together with line_start, pol becomes 0 for that line.
- R8: wid_o and rgt_o take wide_in and right_in at line_start and hold them until the next line_start. A change of the mode inputs during a line has no effect on that line's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 4x shift-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe that begins a line |
| frame_start | input | 1 | With line_start, forces even parity |
| wide_in | input | 1 | Aspect select: 1 wide, 0 narrow |
| right_in | input | 1 | Scan select: 1 right, 0 left |
| hst | output | 1 | Horizontal start pulse |
| hck1 | output | 1 | Shift clock phase 1 |
| hck2 | output | 1 | Shift clock phase 2 |
| sh_ck1 | output | 1 | Sample strobe, first channel |
| sh_ck2 | output | 1 | Sample strobe, second channel |
| sh_ck3 | output | 1 | Sample strobe, third channel |
| pol | output | 1 | Line parity and video/side-black polarity |
| wid_o | output | 1 | Latched aspect mode to panel |
| rgt_o | output | 1 | Latched scan direction to panel |

## Verification
The properties assume that line_start is a single-cycle strobe and that frame_start is asserted only together with it. They also assume that no new line starts before the previous line's last shift-clock period ends. If a line were restarted mid-period, the strobe-order properties, which compare against the previous cycle, would not hold. The stimulus drives each line_start for one cycle and waits past the end of every line before the next one. It toggles the mode inputs only while a line is running, or between lines, so that the mode-latch checks observe a change they must ignore.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;

    parameter int TICKS_PER_BIT  = 4;
    parameter int WIDE_BITS      = 357;
    parameter int NARROW_BITS    = 268;

    typedef struct packed {
        logic        active;
        logic        parity;
        logic        wide;
        logic        right;
        logic [10:0] tick;
    } line_state_t;

    typedef struct packed {
        logic hst;
        logic hck1;
        logic in_line;
        logic [1:0] phase;
    } hdrive_t;

    function automatic int odd_offset(input int tpb);
        return tpb + tpb / 2;
    endfunction

    function automatic int line_ticks(input logic wide, input logic parity,
                                      input int tpb, input int nw, input int nn);
        int off;
        off = parity ? odd_offset(tpb) : 0;
        return off + 1 + (wide ? nw : nn) * tpb;
    endfunction

    function automatic logic [1:0] strobe_phase(input int idx, input logic right);
        if (idx == 0)      return 2'd0;
        else if (idx == 1) return right ? 2'd1 : 2'd2;
        else               return right ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/hdrv_line_seq.sv
module hdrv_line_seq
    import hdrv_pkg::*;
#(
    parameter int TPB = TICKS_PER_BIT,
    parameter int NW  = WIDE_BITS,
    parameter int NN  = NARROW_BITS
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        line_start,
    input  logic        frame_start,
    input  logic        wide_in,
    input  logic        right_in,
    output line_state_t st
);
    line_state_t st_q;
    logic [10:0] last_tick;

    always_comb begin
        last_tick = 11'(line_ticks(st_q.wide, st_q.parity, TPB, NW, NN) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.active <= 1'b0;
            st_q.parity <= 1'b0;
            st_q.wide   <= 1'b1;
            st_q.right  <= 1'b1;
            st_q.tick   <= '0;
        end else if (line_start) begin
            st_q.active <= 1'b1;
            st_q.parity <= frame_start ? 1'b0 : ~st_q.parity;
            st_q.wide   <= wide_in;
            st_q.right  <= right_in;
            st_q.tick   <= '0;
        end else if (st_q.active) begin
            if (st_q.tick == last_tick) begin
                st_q.active <= 1'b0;
            end else begin
                st_q.tick <= st_q.tick + 11'd1;
            end
        end
    end

    assign st = st_q;
endmodule

// File: rtl/hdrv_clk_gen.sv
module hdrv_clk_gen
    import hdrv_pkg::*;
#(
    parameter int TPB = TICKS_PER_BIT,
    parameter int NW  = WIDE_BITS,
    parameter int NN  = NARROW_BITS
) (
    input  line_state_t st,
    output hdrive_t     drv
);
    localparam int OFF_ODD = odd_offset(TPB);
    localparam int PH_W    = $clog2(TPB);

    logic [10:0] off;
    logic [10:0] h0;
    logic [10:0] h_end;
    logic [10:0] rel;

    always_comb begin
        off   = st.parity ? 11'(OFF_ODD) : 11'd0;
        h0    = off + 11'd1;
        h_end = 11'(line_ticks(st.wide, st.parity, TPB, NW, NN));
        rel   = st.tick - h0;
        drv.hst     = st.active && (st.tick >= off) && (st.tick < off + 11'(TPB));
        drv.in_line = st.active && (st.tick >= h0) && (st.tick < h_end);
        drv.phase   = 2'(rel[PH_W-1:0]);
        drv.hck1    = drv.in_line && (32'(rel[PH_W-1:0]) < TPB / 2);
    end
endmodule

// File: rtl/hdrv_strobe_gen.sv
module hdrv_strobe_gen
    import hdrv_pkg::*;
#(
    parameter int N_STROBE = 3
) (
    input  logic                in_line,
    input  logic [1:0]          phase,
    input  logic                right,
    output logic [N_STROBE-1:0] strobe
);
    for (genvar i = 0; i < N_STROBE; i++) begin : g_strobe
        assign strobe[i] = in_line && (phase == strobe_phase(i, right));
    end
endmodule

// File: rtl/hdrv_timing_top.sv
module hdrv_timing_top
    import hdrv_pkg::*;
#(
    parameter int TPB = TICKS_PER_BIT,
    parameter int NW  = WIDE_BITS,
    parameter int NN  = NARROW_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic line_start,
    input  logic frame_start,
    input  logic wide_in,
    input  logic right_in,
    output logic hst,
    output logic hck1,
    output logic hck2,
    output logic sh_ck1,
    output logic sh_ck2,
    output logic sh_ck3,
    output logic pol,
    output logic wid_o,
    output logic rgt_o
);
    line_state_t st;
    hdrive_t     drv;
    logic [2:0]  strobes;

    hdrv_line_seq #(.TPB(TPB), .NW(NW), .NN(NN)) i_seq (
        .clk(clk), .rst(rst), .line_start(line_start), .frame_start(frame_start),
        .wide_in(wide_in), .right_in(right_in), .st(st)
    );

    hdrv_clk_gen #(.TPB(TPB), .NW(NW), .NN(NN)) i_clk (
        .st(st), .drv(drv)
    );

    hdrv_strobe_gen #(.N_STROBE(3)) i_stb (
        .in_line(drv.in_line), .phase(drv.phase), .right(st.right), .strobe(strobes)
    );

    assign hst    = drv.hst;
    assign hck1   = drv.hck1;
    assign hck2   = ~drv.hck1;
    assign sh_ck1 = strobes[0];
    assign sh_ck2 = strobes[1];
    assign sh_ck3 = strobes[2];
    assign pol    = st.parity;
    assign wid_o  = st.wide;
    assign rgt_o  = st.right;
endmodule

// File: rtl/hdrv_timing_chk.sv
module hdrv_timing_chk (
    input logic clk,
    input logic rst,
    input logic line_start,
    input logic frame_start,
    input logic hst,
    input logic hck1,
    input logic hck2,
    input logic sh_ck1,
    input logic sh_ck2,
    input logic sh_ck3,
    input logic pol,
    input logic wid_o,
    input logic rgt_o
);
    p_hck_compl_r3: assert property (@(posedge clk) disable iff (rst)
        hck1 != hck2);

    p_hst_setup_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(hst) |=> $rose(hck1));

    p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sh_ck1, sh_ck2, sh_ck3}));

    p_ck1_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
        sh_ck1 |-> $rose(hck1));

    p_right_order_r5: assert property (@(posedge clk) disable iff (rst)
        (rgt_o && sh_ck2) |-> $past(sh_ck1));

    p_left_order_r6: assert property (@(posedge clk) disable iff (rst)
        (!rgt_o && sh_ck3) |-> $past(sh_ck1));

    p_pol_flip_r7: assert property (@(posedge clk) disable iff (rst)
        (line_start && !frame_start) |=> (pol != $past(pol)));

    p_pol_even_r7: assert property (@(posedge clk) disable iff (rst)
        (line_start && frame_start) |=> !pol);

    p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !line_start |=> ($stable(wid_o) && $stable(rgt_o)));
endmodule

bind hdrv_timing_top hdrv_timing_chk i_chk (
    .clk(clk), .rst(rst), .line_start(line_start), .frame_start(frame_start),
    .hst(hst), .hck1(hck1), .hck2(hck2), .sh_ck1(sh_ck1), .sh_ck2(sh_ck2),
    .sh_ck3(sh_ck3), .pol(pol), .wid_o(wid_o), .rgt_o(rgt_o)
);

// File: tb/test_hdrv_timing_top.sv
module test_hdrv_timing_top;
    logic clk = 1'b0;
    logic rst, line_start, frame_start, wide_in, right_in;
    logic hst, hck1, hck2, sh_ck1, sh_ck2, sh_ck3, pol, wid_o, rgt_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic exp_par = 1'b0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    hdrv_timing_top i_hdrv_timing_top (
        .clk(clk), .rst(rst), .line_start(line_start), .frame_start(frame_start),
        .wide_in(wide_in), .right_in(right_in), .hst(hst), .hck1(hck1), .hck2(hck2),
        .sh_ck1(sh_ck1), .sh_ck2(sh_ck2), .sh_ck3(sh_ck3), .pol(pol),
        .wid_o(wid_o), .rgt_o(rgt_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Runs one line and compares every tick against the requirement model.
    task automatic run_line(input logic frame, input logic wide, input logic right,
                            input logic flip_modes);
        int off, h0, nb, total, rises, hst_hi;
        logic prev_h1;
        exp_par = frame ? 1'b0 : ~exp_par;
        off = exp_par ? 6 : 0;
        h0 = off + 1;
        nb = wide ? 357 : 268;
        total = h0 + nb * 4;
        rises = 0;
        hst_hi = 0;
        prev_h1 = 1'b0;
        @(negedge clk);
        line_start = 1'b1; frame_start = frame; wide_in = wide; right_in = right;
        @(posedge clk);
        for (int k = 0; k < total + 4; k++) begin
            logic e_hst, e_in, e_h1, e1, e2, e3;
            int ph;
            @(negedge clk);
            if (k == 0) begin
                line_start = 1'b0; frame_start = 1'b0;
                chk(pol == exp_par, "R7 pol", int'(pol), int'(exp_par));
                chk(wid_o == wide, "R8 wid_o", int'(wid_o), int'(wide));
                chk(rgt_o == right, "R8 rgt_o", int'(rgt_o), int'(right));
            end
            if (flip_modes && k == 10) begin
                wide_in = ~wide; right_in = ~right;
            end
            ph = (k - h0) % 4;
            e_hst = (k >= off) && (k < off + 4);
            e_in  = (k >= h0) && (k < total);
            e_h1  = e_in && (ph < 2);
            e1 = e_in && (ph == 0);
            e2 = e_in && (ph == (right ? 1 : 2));
            e3 = e_in && (ph == (right ? 2 : 1));
            if (hst) hst_hi++;
            if (hck1 && !prev_h1) rises++;
            prev_h1 = hck1;
            chk(hst == e_hst, "R2 hst", int'(hst), int'(e_hst));
            chk(hck1 == e_h1, "R4 hck1", int'(hck1), int'(e_h1));
            chk(hck2 == ~hck1, "R3 hck2", int'(hck2), int'(~hck1));
            chk(sh_ck1 == e1, "R5 sh_ck1", int'(sh_ck1), int'(e1));
            chk(sh_ck2 == e2, right ? "R5 sh_ck2" : "R6 sh_ck2", int'(sh_ck2), int'(e2));
            chk(sh_ck3 == e3, right ? "R5 sh_ck3" : "R6 sh_ck3", int'(sh_ck3), int'(e3));
        end
        chk(hst_hi == 4, "R2 hst width", hst_hi, 4);
        chk(rises == nb, "R4 period count", rises, nb);
        chk(wid_o == wide, "R8 wid_o held", int'(wid_o), int'(wide));
        chk(rgt_o == right, "R8 rgt_o held", int'(rgt_o), int'(right));
    endtask

    task automatic t_reset();
        rst = 1'b1; line_start = 1'b0; frame_start = 1'b0; wide_in = 1'b0; right_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(hst == 1'b0, "R1 hst", int'(hst), 0);
        chk(hck1 == 1'b0, "R1 hck1", int'(hck1), 0);
        chk(hck2 == 1'b1, "R1 hck2", int'(hck2), 1);
        chk({sh_ck1, sh_ck2, sh_ck3} == 3'b000, "R1 strobes", int'({sh_ck1, sh_ck2, sh_ck3}), 0);
        chk(pol == 1'b0, "R1 pol", int'(pol), 0);
        chk(wid_o == 1'b1, "R1 wid_o", int'(wid_o), 1);
        chk(rgt_o == 1'b1, "R1 rgt_o", int'(rgt_o), 1);
        exp_par = 1'b0;
    endtask

    task automatic t_wide_right_pair();
        run_line(1'b1, 1'b1, 1'b1, 1'b0);
        run_line(1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_narrow_left_pair();
        run_line(1'b0, 1'b0, 1'b0, 1'b0);
        run_line(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_mode_change_mid_line();
        run_line(1'b0, 1'b1, 1'b0, 1'b1);
        run_line(1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_frame_resets_parity();
        run_line(1'b0, 1'b1, 1'b1, 1'b0);
        run_line(1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_wide_right_pair();
        t_narrow_left_pair();
        t_mode_change_mid_line();
        t_frame_resets_parity();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule